// File: doc/BRIEF.md
# Power-Domain Head-Switch Sequencer

This block controls one switchable power domain from a reference-oscillator clock. It sequences a collapse (power-down) and a restore (power-up) of the domain. Its outputs are a clock gate, an enable for a small first group of head switches, an enable for the remaining switches, an I/O clamp and a domain reset. The power-up enables the small group first so that inrush current stays low. Each timed phase lasts 2^n reference cycles, where n comes from a 4-bit field that software programs.

Software uses a plain register port with two 32-bit words. A control word at offset 0x0 holds the collapse request, the hardware-mode enable, the sequencer bypass, the three wait fields and a read-only power-on flag. A configuration/status word at offset 0x4 holds the up-complete and down-complete flags and a retention enable. In hardware mode an external request pin decides the direction in place of the software collapse bit.

Top module: `hsw_domain_ctl`

## Requirements
- R1: After reset the control word reads 0x00282001, meaning collapse request set and wait fields rest=2, few=8, clock=2. The status word reads 0x00008000. The domain is off: clock gate, clamp and reset are high, both switch enables are low, and power-on is low.
- R2: The wait fields sit in the control word at bits 23:20 (before the rest enable phase ends), 19:16 (after the few enable) and 15:12 (clock-disable). A field value n holds its phase for exactly 2^n clock cycles.
- R3: Power-up order: the few enable rises and down-complete clears. After 2^few cycles the rest enable rises. After 2^rest cycles the clamp and reset drop. One cycle later the clock gate drops. One cycle after that, power-on and up-complete rise.
- R4: Power-down order: the clock gate rises and up-complete clears. After 2^clk cycles the clamp and reset rise. One cycle later both switch enables drop together. One cycle after that, down-complete rises and power-on falls.
- R5: After a new direction request, all outputs keep their old values for 8 cycles before the sequence begins. A control write takes effect at the clock edge it is written on, so the first change comes 9 cycles after that edge. The request pin is sampled one edge sooner.
- R6: Control bit 31 reads power-on; status bit 16 reads up-complete and bit 15 reads down-complete. Writes to these bits have no effect.
- R7: A request that reverses direction during a sequence does not cut it short. The running sequence completes to a stable state, and the new direction then starts a fresh sequence.
- R8: With control bit 1 set, the request pin sets the direction (1 means collapse), and the software collapse bit (bit 0) is ignored.
- R9: Clearing hardware mode while the collapse bit is 0 makes a collapsed domain power up, and power-on rises once that power-up completes.
- R10: With control bit 2 set, the switches, clamp, reset and clock gate follow the collapse bit in the same cycle. The sequencer and the status flags stay frozen.
- R11: Status word bit 11 is a read/write retention enable that drives the retain output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset (0x0 control, 0x4 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| hw_req | input | 1 | Hardware collapse request (1 = off) |
| clk_dis | output | 1 | Domain clock gate |
| few_en | output | 1 | First small switch group enable |
| rest_en | output | 1 | Remaining switch group enable |
| clamp | output | 1 | I/O clamp |
| dom_rst | output | 1 | Domain reset |
| retain_ff | output | 1 | Retention flip-flop enable |
| pwr_on | output | 1 | Domain fully powered |
| up_done | output | 1 | Power-up complete |
| down_done | output | 1 | Power-down complete |

## Verification
The scoreboard records the cycle of every output change. An off-by-one wait counter shows up as a timing mismatch at field values 0, 3 and 8, and a missing 8-cycle lag shows up as changes that come too early. A reversed request written in the middle of a power-down must not abort it. A design that aborted it would start the power-up before down-complete is reached, so the observed sequence would be missing steps. The bench also checks that the software collapse bit has no effect in hardware mode, since a design that leaked it would collapse the domain. It checks that the bypass mode changes the drive outputs but not the status flags, and that the read-only flags ignore writes.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  // Field width of one wait exponent
  localparam int WFW = 4;

  // Control word bit positions
  localparam int CTL_COLLAPSE = 0;
  localparam int CTL_HWMODE   = 1;
  localparam int CTL_BYPASS   = 2;
  localparam int CTL_CLKW_LSB = 12;
  localparam int CTL_FEWW_LSB = 16;
  localparam int CTL_RSTW_LSB = 20;
  localparam int CTL_PWRON    = 31;

  // Status word bit positions
  localparam int STS_RETAIN   = 11;
  localparam int STS_DNDONE   = 15;
  localparam int STS_UPDONE   = 16;

  typedef struct packed {
    logic [WFW-1:0] rest_w;
    logic [WFW-1:0] few_w;
    logic [WFW-1:0] clk_w;
    logic           bypass;
    logic           hw_mode;
    logic           collapse;
  } ctl_s;

  localparam ctl_s CTL_RST = '{rest_w: 4'd2, few_w: 4'd8, clk_w: 4'd2,
                               bypass: 1'b0, hw_mode: 1'b0, collapse: 1'b1};

  typedef struct packed {
    logic clk_dis;
    logic few;
    logic rest;
    logic clamp;
    logic rst;
  } drive_s;

  typedef struct packed {
    logic pwr_on;
    logic up_done;
    logic down_done;
  } stat_s;

  typedef enum logic [3:0] {
    ST_OFF, ST_LAG_UP, ST_FEW, ST_REST, ST_RELEASE, ST_UNGATE, ST_ON,
    ST_LAG_DN, ST_CLK_OFF, ST_CLAMP, ST_CUT
  } seq_st_e;

endpackage

// File: rtl/hsw_wait_timer.sv
module hsw_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_ce = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/hsw_regs.sv
module hsw_regs
  import hsw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  stat_s             stat,
  output ctl_s              ctl,
  output logic              retain
);

  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STS_OFS = ADDR_W'(4);

  ctl_s ctl_q, ctl_d;
  logic ret_q, ret_d;
  logic ctl_we, sts_we;
  logic wdata_unused;

  assign ctl_we = bus_en & bus_we & (bus_addr == CTL_OFS);
  assign sts_we = bus_en & bus_we & (bus_addr == STS_OFS);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.rest_w   = bus_wdata[CTL_RSTW_LSB +: WFW];
      ctl_d.few_w    = bus_wdata[CTL_FEWW_LSB +: WFW];
      ctl_d.clk_w    = bus_wdata[CTL_CLKW_LSB +: WFW];
      ctl_d.bypass   = bus_wdata[CTL_BYPASS];
      ctl_d.hw_mode  = bus_wdata[CTL_HWMODE];
      ctl_d.collapse = bus_wdata[CTL_COLLAPSE];
    end
  end

  always_comb begin
    ret_d = ret_q;
    if (sts_we) ret_d = bus_wdata[STS_RETAIN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= 1'b0;
    else if (sts_we) ret_q <= ret_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == CTL_OFS) begin
        bus_rdata[CTL_PWRON]              = stat.pwr_on;
        bus_rdata[CTL_RSTW_LSB +: WFW]    = ctl_q.rest_w;
        bus_rdata[CTL_FEWW_LSB +: WFW]    = ctl_q.few_w;
        bus_rdata[CTL_CLKW_LSB +: WFW]    = ctl_q.clk_w;
        bus_rdata[CTL_BYPASS]             = ctl_q.bypass;
        bus_rdata[CTL_HWMODE]             = ctl_q.hw_mode;
        bus_rdata[CTL_COLLAPSE]           = ctl_q.collapse;
      end else if (bus_addr == STS_OFS) begin
        bus_rdata[STS_UPDONE] = stat.up_done;
        bus_rdata[STS_DNDONE] = stat.down_done;
        bus_rdata[STS_RETAIN] = ret_q;
      end
    end
  end

  assign wdata_unused = ^{bus_wdata[31:24], bus_wdata[10:3], bus_wdata[31:17]};
  assign ctl          = ctl_q;
  assign retain       = ret_q;

endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int LAG_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_off,
  input  logic           freeze,
  input  logic [WFW-1:0] clk_w,
  input  logic [WFW-1:0] few_w,
  input  logic [WFW-1:0] rest_w,
  output drive_s         drv,
  output stat_s          stat
);

  localparam int EXP_W = 2 ** WFW;
  localparam int LAG_W = $clog2(LAG_CYC) + 1;
  localparam int CNT_W = (EXP_W > LAG_W) ? EXP_W : LAG_W;
  localparam logic [CNT_W-1:0] LAG_LD = CNT_W'(LAG_CYC - 1);

  seq_st_e          st_q, st_d;
  logic             tm_load, tm_done;
  logic [CNT_W-1:0] tm_val;

  function automatic logic [CNT_W-1:0] span(input logic [WFW-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction

  hsw_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!freeze),
    .load     (tm_load),
    .load_val (tm_val),
    .done     (tm_done)
  );

  // Next-state logic; direction is only sampled in the two stable states
  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    if (!freeze) begin
      case (st_q)
        ST_OFF: if (!go_off) begin
          st_d = ST_LAG_UP; tm_load = 1'b1; tm_val = LAG_LD;
        end
        ST_LAG_UP: if (tm_done) begin
          st_d = ST_FEW; tm_load = 1'b1; tm_val = span(few_w);
        end
        ST_FEW: if (tm_done) begin
          st_d = ST_REST; tm_load = 1'b1; tm_val = span(rest_w);
        end
        ST_REST:    if (tm_done) st_d = ST_RELEASE;
        ST_RELEASE: st_d = ST_UNGATE;
        ST_UNGATE:  st_d = ST_ON;
        ST_ON: if (go_off) begin
          st_d = ST_LAG_DN; tm_load = 1'b1; tm_val = LAG_LD;
        end
        ST_LAG_DN: if (tm_done) begin
          st_d = ST_CLK_OFF; tm_load = 1'b1; tm_val = span(clk_w);
        end
        ST_CLK_OFF: if (tm_done) st_d = ST_CLAMP;
        ST_CLAMP:   st_d = ST_CUT;
        ST_CUT:     st_d = ST_OFF;
        default:    st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // Moore decode of drive and status
  always_comb begin
    drv  = '{clk_dis: 1'b1, few: 1'b0, rest: 1'b0, clamp: 1'b1, rst: 1'b1};
    stat = '{pwr_on: 1'b0, up_done: 1'b0, down_done: 1'b0};
    case (st_q)
      ST_OFF, ST_LAG_UP: stat.down_done = 1'b1;
      ST_FEW: drv.few = 1'b1;
      ST_REST: begin
        drv.few = 1'b1; drv.rest = 1'b1;
      end
      ST_RELEASE: begin
        drv.few = 1'b1; drv.rest = 1'b1; drv.clamp = 1'b0; drv.rst = 1'b0;
      end
      ST_UNGATE: begin
        drv = '{clk_dis: 1'b0, few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0};
      end
      ST_ON, ST_LAG_DN: begin
        drv  = '{clk_dis: 1'b0, few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0};
        stat = '{pwr_on: 1'b1, up_done: 1'b1, down_done: 1'b0};
      end
      ST_CLK_OFF: begin
        drv = '{clk_dis: 1'b1, few: 1'b1, rest: 1'b1, clamp: 1'b0, rst: 1'b0};
        stat.pwr_on = 1'b1;
      end
      ST_CLAMP: begin
        drv = '{clk_dis: 1'b1, few: 1'b1, rest: 1'b1, clamp: 1'b1, rst: 1'b1};
        stat.pwr_on = 1'b1;
      end
      ST_CUT: stat.pwr_on = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/hsw_domain_ctl.sv
module hsw_domain_ctl
  import hsw_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LAG_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_req,
  output logic              clk_dis,
  output logic              few_en,
  output logic              rest_en,
  output logic              clamp,
  output logic              dom_rst,
  output logic              retain_ff,
  output logic              pwr_on,
  output logic              up_done,
  output logic              down_done
);

  ctl_s   ctl;
  stat_s  stat;
  drive_s seq_drv;
  logic   bypass_mode;
  logic   go_off;

  assign bypass_mode = ctl.bypass;
  assign go_off      = ctl.hw_mode ? hw_req : ctl.collapse;

  hsw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stat      (stat),
    .ctl       (ctl),
    .retain    (retain_ff)
  );

  hsw_seq #(.LAG_CYC(LAG_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_off (go_off),
    .freeze (bypass_mode),
    .clk_w  (ctl.clk_w),
    .few_w  (ctl.few_w),
    .rest_w (ctl.rest_w),
    .drv    (seq_drv),
    .stat   (stat)
  );

  // Bypass: drive pins straight from the collapse bit
  assign clk_dis   = bypass_mode ?  ctl.collapse : seq_drv.clk_dis;
  assign few_en    = bypass_mode ? !ctl.collapse : seq_drv.few;
  assign rest_en   = bypass_mode ? !ctl.collapse : seq_drv.rest;
  assign clamp     = bypass_mode ?  ctl.collapse : seq_drv.clamp;
  assign dom_rst   = bypass_mode ?  ctl.collapse : seq_drv.rst;
  assign pwr_on    = stat.pwr_on;
  assign up_done   = stat.up_done;
  assign down_done = stat.down_done;

endmodule

// File: rtl/hsw_domain_ctl_chk.sv
module hsw_domain_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_dis,
  input logic few_en,
  input logic rest_en,
  input logic clamp,
  input logic dom_rst,
  input logic pwr_on,
  input logic up_done,
  input logic down_done,
  input logic bypass
);

  a_r4_clamp_under_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp) |-> clk_dis);

  a_r3_rest_after_few: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rest_en) |-> few_en);

  a_r3_on_fully_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> (few_en && rest_en && !clamp && !dom_rst && !clk_dis));

  a_r4_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> (clamp && dom_rst && clk_dis && !few_en && !rest_en));

  a_r4_done_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
    (down_done && !bypass) |-> (!few_en && !rest_en && clamp));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_done && down_done));

  a_r10_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |->
      ($stable(pwr_on) && $stable(up_done) && $stable(down_done)));

endmodule

bind hsw_domain_ctl hsw_domain_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_dis   (clk_dis),
  .few_en    (few_en),
  .rest_en   (rest_en),
  .clamp     (clamp),
  .dom_rst   (dom_rst),
  .pwr_on    (pwr_on),
  .up_done   (up_done),
  .down_done (down_done),
  .bypass    (bypass_mode)
);

// File: tb/hsw_domain_ctl_bench.sv
module hsw_domain_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_req = 1'b0;
  logic        clk_dis, few_en, rest_en, clamp, dom_rst, retain_ff;
  logic        pwr_on, up_done, down_done;

  hsw_domain_ctl u_hsw_domain_ctl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_req(hw_req), .clk_dis(clk_dis), .few_en(few_en), .rest_en(rest_en),
    .clamp(clamp), .dom_rst(dom_rst), .retain_ff(retain_ff),
    .pwr_on(pwr_on), .up_done(up_done), .down_done(down_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] vec;
    int         at;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] last_vec;
  wire  [7:0] vec_w = {clk_dis, few_en, rest_en, clamp, dom_rst, pwr_on, up_done, down_done};

  // Vector codes {clk_dis,few,rest,clamp,rst,pwr_on,up_done,down_done}
  localparam logic [7:0] V_OFF = 8'h99, V_FEW = 8'hD8, V_REST = 8'hF8;
  localparam logic [7:0] V_REL = 8'hE0, V_UNG = 8'h60, V_ON = 8'h66;
  localparam logic [7:0] V_GATE = 8'hE4, V_CLMP = 8'hFC, V_CUT = 8'h9C;
  localparam logic [7:0] V_BYP_OFF = 8'h9E;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // Monitor: pops one expected item per observed output change
  always @(negedge clk) begin
    if (!rst_n) last_vec = vec_w;
    else if (vec_w !== last_vec) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3 R4 R8 R10 unexpected change: actual %h at %0d expected none", vec_w, cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (vec_w !== e.vec || cyc != e.at) begin
          n_bad++;
          $display("FAIL %s: actual %h at %0d expected %h at %0d", e.tag, vec_w, cyc, e.vec, e.at);
        end
      end
      last_vec = vec_w;
    end
  end

  task automatic push(input logic [7:0] v, input int at, input string tag);
    exp_t e;
    e.vec = v; e.at = at; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // W: edge where the request is registered; sequencer reacts at W+1
  task automatic up_seq(input int w, input int f, input int r, input string tag, output int t_on);
    int t;
    t = w + 9;                 push(V_FEW,  t, {tag, " R3 R5 few"});
    t = t + (1 << f);          push(V_REST, t, {tag, " R2 R3 rest"});
    t = t + (1 << r);          push(V_REL,  t, {tag, " R2 R3 release"});
    t = t + 1;                 push(V_UNG,  t, {tag, " R3 ungate"});
    t = t + 1;                 push(V_ON,   t, {tag, " R3 on"});
    t_on = t;
  endtask

  task automatic dn_seq(input int w, input int c, input string tag, output int t_off);
    int t;
    t = w + 9;                 push(V_GATE, t, {tag, " R4 R5 gate"});
    t = t + (1 << c);          push(V_CLMP, t, {tag, " R2 R4 clamp"});
    t = t + 1;                 push(V_CUT,  t, {tag, " R4 cut"});
    t = t + 1;                 push(V_OFF,  t, {tag, " R4 off"});
    t_off = t;
  endtask

  task automatic next_w(output int w);
    @(negedge clk);
    w = cyc + 1;
  endtask

  task automatic drive_wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, bus_rdata, exp);
    end
    bus_en = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drain(input string tag);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: actual %0d pending expected 0", tag, sb_q.size());
    end
  endtask

  initial begin
    int w, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd(4'h0, 32'h00282001, "R1 control reset");
    chk_rd(4'h4, 32'h00008000, "R1 status reset");
    n_chk++;
    if (vec_w !== V_OFF) begin
      n_bad++;
      $display("FAIL R1 outputs: actual %h expected %h", vec_w, V_OFF);
    end

    // R3 power-up with default waits
    next_w(w); up_seq(w, 8, 2, "default-up", t); drive_wr(4'h0, 32'h00282000);
    drain("R3 default up");
    chk_rd(4'h0, 32'h80282000, "R6 power-on bit");
    chk_rd(4'h4, 32'h00010000, "R6 up-complete bit");

    // R4 power-down, clock wait 3; bit 31 written but read-only
    next_w(w); dn_seq(w, 3, "down-c3", t); drive_wr(4'h0, 32'h80123001);
    drain("R4 down");
    chk_rd(4'h0, 32'h00123001, "R6 bit31 read-only");
    chk_rd(4'h4, 32'h00008000, "R6 down-complete bit");

    // R2 minimum waits
    next_w(w); up_seq(w, 0, 0, "min-up", t); drive_wr(4'h0, 32'h00000000);
    drain("R2 min up");

    // R7 reversal in mid power-down
    next_w(w); dn_seq(w, 4, "rev-down R7", t); up_seq(t, 0, 0, "rev-up R7", t);
    drive_wr(4'h0, 32'h00004001);
    repeat (9) @(negedge clk);
    drive_wr(4'h0, 32'h00004000);
    drain("R7 reversal");

    // R8 hardware mode: software collapse ignored
    drive_wr(4'h0, 32'h00000003);
    repeat (30) @(negedge clk);
    n_chk++;
    if (vec_w !== V_ON) begin
      n_bad++;
      $display("FAIL R8 collapse bit ignored: actual %h expected %h", vec_w, V_ON);
    end
    @(negedge clk); w = cyc; dn_seq(w, 0, "hw-down R8", t); hw_req = 1'b1;
    drain("R8 hw down");

    // R9 handover back to software powers up
    next_w(w); up_seq(w, 0, 0, "handover R9", t); drive_wr(4'h0, 32'h00000000);
    drain("R9 handover");
    chk_rd(4'h0, 32'h80000000, "R9 power-on after handover");

    // R10 bypass
    next_w(w); push(V_BYP_OFF, w, "R10 bypass off"); drive_wr(4'h0, 32'h00000005);
    repeat (20) @(negedge clk);
    next_w(w); push(V_ON, w, "R10 bypass on"); drive_wr(4'h0, 32'h00000004);
    drive_wr(4'h0, 32'h00000000);
    repeat (20) @(negedge clk);
    drain("R10 bypass");
    n_chk++;
    if (vec_w !== V_ON) begin
      n_bad++;
      $display("FAIL R10 after bypass: actual %h expected %h", vec_w, V_ON);
    end

    // R11 retention bit
    drive_wr(4'h4, 32'hFFFFFFFF);
    chk_rd(4'h4, 32'h00010800, "R11 retain set, R6 flags read-only");
    chk_bit(retain_ff, 1'b1, "R11 retain pin high");
    drive_wr(4'h4, 32'h00000000);
    chk_rd(4'h4, 32'h00010000, "R11 retain clear");
    chk_bit(retain_ff, 1'b0, "R11 retain pin low");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule